// File: doc/BRIEF.md
# Granularity-Configurable Word Packer

This block turns a stream of source words of width `IN_W` into a stream of channel words of width `CH_W`. Each source word is first cut into fragments of `FRAG_W` bits. As many whole fragments as fit are then laid side by side in a channel word. One datapath therefore narrows wide words (splitting) or merges narrow ones (packing). The fragment width is fixed when the block is built. It trades channel fill against the number of fragment moves:

- `FRAG_W = 1` packs bit by bit, leaving slack only in the closing word.
- `FRAG_W = IN_W` places whole source words, so every word may carry slack.
- `FRAG_W = CH_W` puts one source word into each channel word.

Both sides use valid/ready handshakes. A source word flagged as last closes a packet. Whatever fragments are still collected are then sent in one final, possibly partial, channel word, and that word carries the output last flag. The block moves, in each cycle, as many fragments as both the held source word and the free channel slots allow.

Top module: `gran_packer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: An accepted source word is cut into ceil(IN_W/FRAG_W) fragments. Fragment k holds source bits k*FRAG_W upward, and any positions past bit IN_W-1 read as zero.
- R3: Fragments enter channel slots in arrival order. Slot s occupies bits s*FRAG_W to s*FRAG_W+FRAG_W-1, and slot 0 is at the LSB. No fragment is divided between two channel words. A channel word that is not the last of its packet is sent only when all floor(CH_W/FRAG_W) slots are filled.
- R4: Bits of a channel word not covered by a filled slot are 0. This includes any bits above FRAG_W*floor(CH_W/FRAG_W).
- R5: A packet of n source words yields exactly ceil(n*ceil(IN_W/FRAG_W)/floor(CH_W/FRAG_W)) channel words.
- R6: When the last source word of a packet has been placed, the collected fragments are sent at once as a channel word with `out_last` = 1. `out_last` is 0 on every other word, and no fragment of the next packet shares that word.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` stay unchanged into the next cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0.
- R9: With FRAG_W = 1, bits are packed contiguously across source-word boundaries.
- R10: With FRAG_W = IN_W and IN_W < CH_W, each channel word holds floor(CH_W/IN_W) whole source words, and the remaining upper bits are zero.
- R11: With FRAG_W = CH_W, each source word occupies its own channel word, zero-extended.
- R12: With IN_W > CH_W, each source word is split over several channel words by the same fragment rule, including a zero-padded partial top fragment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source word offered |
| in_ready | output | 1 | Block accepts the source word this cycle |
| in_data | input | IN_W | Source word |
| in_last | input | 1 | Source word closes its packet |
| out_valid | output | 1 | Channel word offered |
| out_ready | input | 1 | Downstream takes the channel word this cycle |
| out_data | output | CH_W | Channel word, slot 0 at the LSB |
| out_last | output | 1 | Final channel word of a packet |

## Verification
The properties assume a legal build, with FRAG_W from 1 up to CH_W. They make no assumption about `out_ready`, which may drop in any cycle. The checks on held-fragment flushing also assume that a source word offered with `in_last` belongs to the packet it closes. The stimulus keeps each offered word and its last flag stable until `in_ready` accepts it, and always closes a packet with `in_last`. It draws `out_ready` at random, with per-packet probabilities ranging from always-ready to a heavy stall. It covers five builds: bitwise, per-word, word-per-channel-word, a padded 4-bit split and a padded 3-bit split.

// File: rtl/gran_pkg.sv
package gran_pkg;

  // ceiling division for positive operands
  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // fragments needed to carry one source word
  function automatic int frags_per_src(input int src_w, input int frag_w);
    return cdiv(src_w, frag_w);
  endfunction

  // whole fragments that fit in one channel word
  function automatic int slots_per_chan(input int chan_w, input int frag_w);
    return chan_w / frag_w;
  endfunction

  function automatic int umin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int umax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // true when slot j lies inside the window [base, base+n)
  function automatic bit in_window(input int j, input int base, input int n);
    return (j >= base) && (j < base + n);
  endfunction

endpackage

// File: rtl/gp_frag_hold.sv
module gp_frag_hold
  import gran_pkg::*;
#(
  parameter int IN_W   = 10,
  parameter int FRAG_W = 4,
  parameter int FPI    = frags_per_src(IN_W, FRAG_W),
  parameter int CNT_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [IN_W-1:0]        src_data,
  input  logic                   src_last,
  input  logic [CNT_W-1:0]       take,
  output logic                   hold_v,
  output logic                   hold_last,
  output logic [CNT_W-1:0]       hold_rem,
  output logic [FPI*FRAG_W-1:0]  hold_data
);
  localparam int PAD_W = FPI * FRAG_W;

  logic                 v_q;
  logic                 last_q;
  logic [CNT_W-1:0]     rem_q;
  logic [PAD_W-1:0]     data_q;
  logic                 drained;

  // the held word empties when this cycle takes all of its remaining fragments
  assign drained = (take != '0) && (take == rem_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      last_q <= 1'b0;
      rem_q  <= '0;
      data_q <= '0;
    end else if (load) begin
      v_q    <= 1'b1;
      last_q <= src_last;
      rem_q  <= CNT_W'(FPI);
      data_q <= PAD_W'(src_data);
    end else if (take != '0) begin
      rem_q  <= rem_q - take;
      data_q <= data_q >> (int'(take) * FRAG_W);
      if (drained) begin
        v_q    <= 1'b0;
        last_q <= 1'b0;
      end
    end
  end

  assign hold_v    = v_q;
  assign hold_last = last_q;
  assign hold_rem  = rem_q;
  assign hold_data = data_q;

endmodule

// File: rtl/gp_slot_fill.sv
module gp_slot_fill
  import gran_pkg::*;
#(
  parameter int CH_W   = 16,
  parameter int FRAG_W = 4,
  parameter int FPI    = 3,
  parameter int FPC    = 4,
  parameter int CNT_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hold_v,
  input  logic                   hold_last,
  input  logic [CNT_W-1:0]       hold_rem,
  input  logic [FPI*FRAG_W-1:0]  hold_data,
  input  logic                   out_free,
  output logic [CNT_W-1:0]       take,
  output logic                   fin,
  output logic                   emit_v,
  output logic                   emit_last,
  output logic [CNT_W-1:0]       emit_cnt,
  output logic [CH_W-1:0]        emit_data,
  output logic [CNT_W-1:0]       acc_cnt
);
  localparam int MAXF   = umax(FPI, FPC);
  localparam int WIDE_W = MAXF * FRAG_W;
  localparam int ACC_W  = FPC * FRAG_W;

  logic [ACC_W-1:0]  acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ACC_W-1:0]  merged;
  logic [WIDE_W-1:0] wide;
  logic              move;
  int                ac_i;
  int                rm_i;
  int                tk_i;
  int                nc_i;

  assign wide = WIDE_W'(hold_data);
  assign move = hold_v && out_free;

  always_comb begin
    ac_i   = int'(cnt_q);
    rm_i   = int'(hold_rem);
    tk_i   = move ? umin(rm_i, FPC - ac_i) : 0;
    nc_i   = ac_i + tk_i;
    merged = acc_q;
    for (int j = 0; j < FPC; j++) begin
      if (in_window(j, ac_i, tk_i)) begin
        merged[j*FRAG_W +: FRAG_W] = wide[(j-ac_i)*FRAG_W +: FRAG_W];
      end
    end
  end

  assign take      = CNT_W'(tk_i);
  assign fin       = move && (tk_i == rm_i);
  assign emit_v    = move && ((nc_i == FPC) || (fin && hold_last));
  assign emit_last = emit_v && fin && hold_last;
  assign emit_cnt  = CNT_W'(nc_i);
  assign emit_data = CH_W'(merged);
  assign acc_cnt   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (emit_v) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (move) begin
      acc_q <= merged;
      cnt_q <= CNT_W'(nc_i);
    end
  end

endmodule

// File: rtl/gp_out_stage.sv
module gp_out_stage #(
  parameter int CH_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            emit_v,
  input  logic            emit_last,
  input  logic [CH_W-1:0] emit_data,
  input  logic            out_ready,
  output logic            out_free,
  output logic            out_valid,
  output logic            out_last,
  output logic [CH_W-1:0] out_data
);
  logic            v_q;
  logic            l_q;
  logic [CH_W-1:0] d_q;

  assign out_free = !v_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      l_q <= 1'b0;
      d_q <= '0;
    end else if (emit_v) begin
      v_q <= 1'b1;
      l_q <= emit_last;
      d_q <= emit_data;
    end else if (out_ready) begin
      v_q <= 1'b0;
    end
  end

  assign out_valid = v_q;
  assign out_last  = l_q;
  assign out_data  = d_q;

endmodule

// File: rtl/gran_packer.sv
module gran_packer
  import gran_pkg::*;
#(
  parameter int IN_W   = 10,
  parameter int CH_W   = 16,
  parameter int FRAG_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IN_W-1:0] in_data,
  input  logic            in_last,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [CH_W-1:0] out_data,
  output logic            out_last
);
  localparam int FPI   = frags_per_src(IN_W, FRAG_W);
  localparam int FPC   = slots_per_chan(CH_W, FRAG_W);
  localparam int MAXF  = umax(FPI, FPC);
  localparam int CNT_W = $clog2(MAXF + 1);

  // named internal events, also watched by the checker
  logic                  load_w;
  logic                  hold_v;
  logic                  hold_last;
  logic [CNT_W-1:0]      hold_rem;
  logic [FPI*FRAG_W-1:0] hold_data;
  logic [CNT_W-1:0]      take_w;
  logic                  fin_w;
  logic                  emit_v;
  logic                  emit_last;
  logic [CNT_W-1:0]      emit_cnt;
  logic [CH_W-1:0]       emit_data;
  logic [CNT_W-1:0]      acc_cnt;
  logic                  out_free;

  // accept a new word when the holder is empty or drains this cycle,
  // and never while a finished word waits downstream
  assign in_ready = out_free && (!hold_v || fin_w);
  assign load_w   = in_valid && in_ready;

  gp_frag_hold #(
    .IN_W(IN_W), .FRAG_W(FRAG_W), .FPI(FPI), .CNT_W(CNT_W)
  ) u_hold (
    .clk(clk), .rst_n(rst_n),
    .load(load_w), .src_data(in_data), .src_last(in_last),
    .take(take_w),
    .hold_v(hold_v), .hold_last(hold_last),
    .hold_rem(hold_rem), .hold_data(hold_data)
  );

  gp_slot_fill #(
    .CH_W(CH_W), .FRAG_W(FRAG_W), .FPI(FPI), .FPC(FPC), .CNT_W(CNT_W)
  ) u_fill (
    .clk(clk), .rst_n(rst_n),
    .hold_v(hold_v), .hold_last(hold_last),
    .hold_rem(hold_rem), .hold_data(hold_data),
    .out_free(out_free),
    .take(take_w), .fin(fin_w),
    .emit_v(emit_v), .emit_last(emit_last), .emit_cnt(emit_cnt),
    .emit_data(emit_data), .acc_cnt(acc_cnt)
  );

  gp_out_stage #(
    .CH_W(CH_W)
  ) u_out (
    .clk(clk), .rst_n(rst_n),
    .emit_v(emit_v), .emit_last(emit_last), .emit_data(emit_data),
    .out_ready(out_ready), .out_free(out_free),
    .out_valid(out_valid), .out_last(out_last), .out_data(out_data)
  );

endmodule

// File: rtl/gp_chk.sv
module gp_chk #(
  parameter int CH_W  = 16,
  parameter int CNT_W = 4,
  parameter int FPC   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CH_W-1:0]  out_data,
  input logic             out_last,
  input logic             hold_v,
  input logic             hold_last,
  input logic             fin,
  input logic             emit_v,
  input logic             emit_last,
  input logic [CNT_W-1:0] emit_cnt,
  input logic [CNT_W-1:0] acc_cnt
);

  // R7: a stalled channel word is held unchanged
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R8: no source word accepted while the output is blocked
  p_ready_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R3: a word that does not close a packet leaves with every slot filled
  p_full_emit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    emit_v && !emit_last |-> emit_cnt == CNT_W'(FPC));

  // R6: draining the closing source word flushes the collected fragments
  p_last_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin && hold_last |-> emit_v && emit_last);

  // R6: nothing of the closed packet lingers in the slots
  p_clear_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    emit_v && emit_last |=> acc_cnt == '0);

  // R2: an accepted word is held for cutting in the next cycle
  p_accept_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> hold_v);

endmodule

bind gran_packer gp_chk #(.CH_W(CH_W), .CNT_W(CNT_W), .FPC(FPC)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last),
  .hold_v(hold_v), .hold_last(hold_last), .fin(fin_w),
  .emit_v(emit_v), .emit_last(emit_last), .emit_cnt(emit_cnt),
  .acc_cnt(acc_cnt)
);

// File: tb/gran_packer_tb.sv
module gp_lane #(
  parameter int          IN_W   = 10,
  parameter int          CH_W   = 16,
  parameter int          FRAG_W = 4,
  parameter string       TAG    = "R3",
  parameter int unsigned SEED   = 1,
  parameter int          NPKT   = 40
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   n_chk,
  output int   n_bad
);
  // bench-side restatement of the fragment counts
  function automatic int count_frags(input int w, input int g);
    int n = 0;
    for (int b = 0; b < w; b += g) n++;
    return n;
  endfunction

  function automatic int count_slots(input int w, input int g);
    int n = 0;
    while ((n + 1) * g <= w) n++;
    return n;
  endfunction

  localparam int BFPI = count_frags(IN_W, FRAG_W);
  localparam int BFPC = count_slots(CH_W, FRAG_W);

  logic            in_valid, in_ready, in_last, out_valid, out_ready, out_last;
  logic [IN_W-1:0] in_data;
  logic [CH_W-1:0] out_data;

  gran_packer #(.IN_W(IN_W), .CH_W(CH_W), .FRAG_W(FRAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  logic [CH_W-1:0] exp_d[$];
  bit              exp_l[$];
  int              exp_n[$];
  logic [CH_W-1:0] m_word;
  int              m_slot;
  int              words_seen;
  int              rdy_pct;
  bit              stall_prev;
  logic [CH_W-1:0] held_d;
  logic            held_l;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL lane %s %s act=%h exp=%h", TAG, req, act, expv);
    end
  endtask

  // reference: cut bit by bit into fragments, drop each into the next slot
  task automatic model_push(input logic [IN_W-1:0] d, input bit last);
    for (int k = 0; k < BFPI; k++) begin
      for (int b = 0; b < FRAG_W; b++) begin
        int src = k * FRAG_W + b;
        m_word[m_slot * FRAG_W + b] = (src < IN_W) ? d[src] : 1'b0;
      end
      m_slot++;
      if (m_slot == BFPC) begin
        exp_d.push_back(m_word);
        exp_l.push_back(last && (k == BFPI - 1));
        m_word = '0;
        m_slot = 0;
      end
    end
    if (last && m_slot != 0) begin
      exp_d.push_back(m_word);
      exp_l.push_back(1'b1);
      m_word = '0;
      m_slot = 0;
    end
  endtask

  task automatic step(input bit v, input logic [IN_W-1:0] d, input bit l, output bit acc);
    logic [CH_W-1:0] used_mask;
    in_valid  = v;
    in_data   = d;
    in_last   = l;
    out_ready = (($urandom % 100) < rdy_pct);
    #1;
    if (stall_prev) begin
      chk(out_valid && out_data == held_d && out_last == held_l, "R7",
          64'({out_valid, out_last, out_data}), 64'({1'b1, held_l, held_d}));
    end
    stall_prev = 1'b0;
    if (out_valid && !out_ready) begin
      chk(!in_ready, "R8", 64'(in_ready), 64'(0));
      stall_prev = 1'b1;
      held_d     = out_data;
      held_l     = out_last;
    end
    if (out_valid && out_ready) begin
      if (exp_d.size() == 0) begin
        chk(1'b0, "R5 extra word", 64'(out_data), 64'(0));
      end else begin
        logic [CH_W-1:0] ed = exp_d.pop_front();
        bit              el = exp_l.pop_front();
        chk(out_data == ed, {"R2/R3/", TAG, " data"}, 64'(out_data), 64'(ed));
        chk(out_last == el, "R6 last flag", 64'(out_last), 64'(el));
      end
      used_mask = '0;
      for (int b = 0; b < BFPC * FRAG_W; b++) used_mask[b] = 1'b1;
      chk((out_data & ~used_mask) == '0, "R4 pad bits", 64'(out_data), 64'(out_data & used_mask));
      words_seen++;
      if (out_last) begin
        int en = (exp_n.size() != 0) ? exp_n.pop_front() : -1;
        chk(words_seen == en, "R5 word count", 64'(words_seen), 64'(en));
        words_seen = 0;
      end
    end
    acc = in_valid && in_ready;
    if (acc) model_push(d, l);
    @(negedge clk);
  endtask

  initial begin
    int unsigned dummy;
    bit acc;
    done = 1'b0; n_chk = 0; n_bad = 0;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0; out_ready = 1'b0;
    m_word = '0; m_slot = 0; words_seen = 0; rdy_pct = 100;
    stall_prev = 1'b0; held_d = '0; held_l = 1'b0;
    dummy = $urandom(SEED);
    @(posedge rst_n);
    @(negedge clk);
    #1;
    chk(!out_valid, "R1 out_valid", 64'(out_valid), 64'(0));
    chk(in_ready, "R1 in_ready", 64'(in_ready), 64'(1));
    @(negedge clk);
    for (int p = 0; p < NPKT; p++) begin
      int len;
      len = (p == 0) ? 1 : (p == 2) ? 9 : 1 + int'($urandom % 5);
      rdy_pct = (p == 2) ? 100 : (p >= 3 && p < 7) ? 20 : 70;
      exp_n.push_back((len * BFPI + BFPC - 1) / BFPC);
      for (int i = 0; i < len; i++) begin
        logic [IN_W-1:0] d;
        d = (p == 1) ? '1 : IN_W'($urandom);
        if (p > 2 && ($urandom % 3) == 0) step(1'b0, '0, 1'b0, acc);
        acc = 1'b0;
        while (!acc) step(1'b1, d, (i == len - 1), acc);
      end
    end
    rdy_pct = 100;
    for (int t = 0; t < 400 && exp_d.size() != 0; t++) step(1'b0, '0, 1'b0, acc);
    step(1'b0, '0, 1'b0, acc);
    chk(exp_d.size() == 0 && !out_valid, "R5/R6 drained",
        64'(exp_d.size()), 64'(0));
    done = 1'b1;
  end
endmodule

module gran_packer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic d0, d1, d2, d3, d4;
  int   c0, c1, c2, c3, c4;
  int   b0, b1, b2, b3, b4;

  // R9 bitwise, R10 per-word, R11 word per channel word, R12 splitting
  gp_lane #(.IN_W(10), .CH_W(16), .FRAG_W(4),  .TAG("R3"),  .SEED(11)) u_l0 (.clk(clk), .rst_n(rst_n), .done(d0), .n_chk(c0), .n_bad(b0));
  gp_lane #(.IN_W(5),  .CH_W(16), .FRAG_W(1),  .TAG("R9"),  .SEED(22)) u_l1 (.clk(clk), .rst_n(rst_n), .done(d1), .n_chk(c1), .n_bad(b1));
  gp_lane #(.IN_W(5),  .CH_W(16), .FRAG_W(5),  .TAG("R10"), .SEED(33)) u_l2 (.clk(clk), .rst_n(rst_n), .done(d2), .n_chk(c2), .n_bad(b2));
  gp_lane #(.IN_W(5),  .CH_W(16), .FRAG_W(16), .TAG("R11"), .SEED(44)) u_l3 (.clk(clk), .rst_n(rst_n), .done(d3), .n_chk(c3), .n_bad(b3));
  gp_lane #(.IN_W(10), .CH_W(8),  .FRAG_W(3),  .TAG("R12"), .SEED(55)) u_l4 (.clk(clk), .rst_n(rst_n), .done(d4), .n_chk(c4), .n_bad(b4));

  initial begin
    int cyc = 0;
    int extra = 0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    while (!(d0 && d1 && d2 && d3 && d4) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!(d0 && d1 && d2 && d3 && d4)) begin
      extra = 1;
      $display("FAIL watchdog expired act=%0d exp=done", cyc);
    end
    #1;
    $display("== %0d vectors applied, %0d miscompares ==",
             c0 + c1 + c2 + c3 + c4 + extra, b0 + b1 + b2 + b3 + b4 + extra);
    $finish;
  end
endmodule